// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup path of a level-one data cache that starts work before address translation is done. A lookup presents only the untranslated page-offset bits of a virtual address. The set index and the word position both come from those bits, so the tag and data arrays of the selected set are read at once, while the translation unit is still producing the physical page number.

When the page number arrives, all eight way tags are compared against it. A hit returns the selected 64-bit word. A miss sends one 64-byte line request to memory, installs the returned line in a victim way chosen by a tree pseudo-LRU policy that prefers empty ways, and then returns the word. If translation reports a fault, the lookup ends with a fault response and the cache is left unchanged. The default geometry is 64 sets of 8 ways with 64-byte lines, which is 32 KB. The tag is the full 40-bit physical page number.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and every line is invalid, so the first lookup to any address misses.
- R2: The set is `req_voff[11:6]` and the returned word is the 64-bit word at `req_voff[5:3]` of the line. Lines with the same page number in different sets are independent.
- R3: A lookup is accepted when `req_valid` and `req_ready` are both 1. The translation is taken in any later cycle in which `xlat_valid` is 1. A hit raises `resp_valid` for one cycle, in the cycle after the translation. `xlat_valid` is ignored when no lookup is pending.
- R4: A hit needs a valid way whose stored tag equals all 40 bits of `xlat_ppn`. A page number that differs in any single bit, including bit 39, misses.
- R5: On a miss, `mem_req_valid` pulses for exactly one cycle, in the cycle after the translation, with `mem_req_addr` = {ppn, set, 6'b000000}.
- R6: `mem_resp_valid` during a refill installs `mem_resp_line`, with byte 8·k+j of the line in bits [64k+8j+7 : 64k+8j]. In the next cycle `resp_valid` rises with word `req_voff[5:3]` of that line. Later lookups to the line hit.
- R7: A translation with `xlat_fault` = 1 gives `resp_valid` = 1 and `resp_fault` = 1 in the next cycle. It issues no memory request and installs nothing.
- R8: A miss fills the lowest-numbered invalid way of the set first, so eight distinct page numbers can live in one set at the same time.
- R9: In a full set, the victim follows a 7-node tree. Node 0 is the root, and node n has children 2n+1 (bit value 0) and 2n+2 (bit value 1). Every hit or fill sets each node on its path to point away from the way used. For example, after ways 0 to 7 are used in order and then way 0 is hit, the next victim is way 4.
- R10: `req_ready` is 0 while a lookup or refill is pending, and `req_valid` is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_voff | input | 12 | Page-offset bits of the virtual address |
| xlat_valid | input | 1 | Translation result present |
| xlat_fault | input | 1 | Translation reported a fault |
| xlat_ppn | input | 40 | Translated physical page number |
| resp_valid | output | 1 | Response strobe |
| resp_fault | output | 1 | Response is a cancelled lookup |
| resp_data | output | 64 | Returned word |
| mem_req_valid | output | 1 | Line refill request pulse |
| mem_req_addr | output | 52 | Line-aligned physical address |
| mem_resp_valid | input | 1 | Refill line present |
| mem_resp_line | input | 512 | Refill line data |

## Verification
The bench goes after the points where virtual indexing and physical tagging meet. A tag that differs only in its top bit must miss; a design that compared a truncated tag would return stale data instead of requesting the line. A faulted lookup followed by the same lookup without the fault must miss; a design that installed on a fault would hit there. Eight fills in one set followed by eight hits expose a victim choice that overwrites a valid way while an empty one exists. A hit to way 0 followed by a new fill must evict way 4 and nothing else; a wrong tree update shows up as a miss to a different page. Late translations, and request strobes held high during a lookup, check that the lookup waits and does not take a second address.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_REFILL} vipt_state_e;

  // Walk the pseudo-LRU tree from the root along the stored bits.
  function automatic int unsigned tree_victim(input logic [63:0] t, input int unsigned levels);
    int unsigned n = 0;
    for (int unsigned l = 0; l < levels; l++) begin
      n = 2 * n + 1 + (t[n] ? 1 : 0);
    end
    return n - ((32'd1 << levels) - 1);
  endfunction

  // Point every node on the path of `way` away from it.
  function automatic logic [63:0] tree_touch(input logic [63:0] t, input int unsigned way,
                                             input int unsigned levels);
    logic [63:0] r = t;
    int unsigned n = 0;
    int unsigned dir;
    for (int unsigned l = 0; l < levels; l++) begin
      dir  = (way >> (levels - 1 - l)) & 1;
      r[n] = (dir == 0);
      n    = 2 * n + 1 + dir;
    end
    return r;
  endfunction

endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 40,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_vld,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_mem;
    wire              wr_here = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (wr_here) tag_mem[wr_idx] <= wr_tag;
      if (rd_en)   rd_tag[w] <= tag_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_mem   <= '0;
        rd_vld[w] <= 1'b0;
      end else begin
        if (wr_here) vld_mem[wr_idx] <= 1'b1;
        if (rd_en)   rd_vld[w] <= vld_mem[rd_idx];
      end
    end
  end
endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int LINE_W = 512,
  parameter int WORD_W = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic                        clk,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic [WSEL_W-1:0]           rd_wsel,
  output logic [WAYS-1:0][WORD_W-1:0] rd_word,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [LINE_W-1:0]           wr_line
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) line_mem[wr_idx] <= wr_line;
      if (rd_en) rd_word[w] <= line_mem[rd_idx][rd_wsel*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int NODES  = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [WAYS-1:0]  q_vld,
  output logic [WAY_W-1:0] victim
);
  import vipt_pkg::*;

  logic [NODES-1:0] tree_q [SETS];
  logic             found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_idx] <= NODES'(tree_touch(64'(tree_q[touch_idx]), 32'(touch_way), WAY_W));
    end
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!q_vld[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) victim = WAY_W'(tree_victim(64'(tree_q[q_idx]), WAY_W));
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int PPN_W      = 40,
  parameter int PAGE_W     = 12,
  parameter int SETS       = 64,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WSEL_W = $clog2(LINE_W / WORD_W),
  localparam int PA_W   = PPN_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_voff,
  input  logic              xlat_valid,
  input  logic              xlat_fault,
  input  logic [PPN_W-1:0]  xlat_ppn,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [WORD_W-1:0] resp_data,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_line
);
  import vipt_pkg::*;

  vipt_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [WAY_W-1:0]  victim_q;

  logic [WAYS-1:0][PPN_W-1:0]  rd_tag;
  logic [WAYS-1:0]             rd_vld;
  logic [WAYS-1:0][WORD_W-1:0] rd_word;
  logic [WAYS-1:0]             hit_vec;
  logic [WAY_W-1:0]            hit_way;
  logic [WAY_W-1:0]            victim_way;

  // Named internal events, observed by the checker.
  wire accept         = req_valid && req_ready;
  wire lookup_pending = (state_q == ST_LOOKUP);
  wire lookup_active  = lookup_pending && xlat_valid;
  wire lookup_cancel  = lookup_active && xlat_fault;
  wire lookup_hit     = lookup_active && !xlat_fault && (|hit_vec);
  wire lookup_miss    = lookup_active && !xlat_fault && !(|hit_vec);
  wire refill_done    = (state_q == ST_REFILL) && mem_resp_valid;

  wire [IDX_W-1:0]  req_idx  = req_voff[PAGE_W-1:OFF_W];
  wire [WSEL_W-1:0] req_wsel = req_voff[OFF_W-1:OFF_W-WSEL_W];

  assign req_ready = (state_q == ST_IDLE);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == xlat_ppn);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  vipt_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_en(accept), .rd_idx(req_idx), .rd_tag(rd_tag), .rd_vld(rd_vld),
    .wr_en(refill_done), .wr_idx(idx_q), .wr_way(victim_q), .wr_tag(ppn_q)
  );

  vipt_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
    .clk(clk),
    .rd_en(accept), .rd_idx(req_idx), .rd_wsel(req_wsel), .rd_word(rd_word),
    .wr_en(refill_done), .wr_idx(idx_q), .wr_way(victim_q), .wr_line(mem_resp_line)
  );

  vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(lookup_hit || refill_done), .touch_idx(idx_q),
    .touch_way(lookup_hit ? hit_way : victim_q),
    .q_idx(idx_q), .q_vld(rd_vld), .victim(victim_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      wsel_q        <= '0;
      ppn_q         <= '0;
      victim_q      <= '0;
      resp_valid    <= 1'b0;
      resp_fault    <= 1'b0;
      resp_data     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          idx_q   <= req_idx;
          wsel_q  <= req_wsel;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (lookup_cancel) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (lookup_hit) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_data  <= rd_word[hit_way];
            state_q    <= ST_IDLE;
          end else if (lookup_miss) begin
            ppn_q         <= xlat_ppn;
            victim_q      <= victim_way;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= {xlat_ppn, idx_q, {OFF_W{1'b0}}};
            state_q       <= ST_REFILL;
          end
        end
        ST_REFILL: if (mem_resp_valid) begin
          resp_valid <= 1'b1;
          resp_fault <= 1'b0;
          resp_data  <= mem_resp_line[wsel_q*WORD_W +: WORD_W];
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int WAYS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic            mem_req_valid,
  input logic            lookup_hit,
  input logic            lookup_cancel,
  input logic            refill_done,
  input logic [WAYS-1:0] hit_vec
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R5
  AST_FAULT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_cancel |=> (resp_valid && resp_fault && !mem_req_valid)); // R7
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (resp_valid && !resp_fault)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!resp_valid && !mem_req_valid)); // R3
  AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |=> (resp_valid && !resp_fault)); // R6
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_BUSY_BEFORE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(!req_ready)); // R10
endmodule

bind vipt_cache vipt_cache_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .mem_req_valid(mem_req_valid), .lookup_hit(lookup_hit),
  .lookup_cancel(lookup_cancel), .refill_done(refill_done), .hit_vec(hit_vec)
);

// File: tb/sim_vipt_cache.sv
`timescale 1ns/1ps
module sim_vipt_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [11:0]  req_voff = '0;
  logic         xlat_valid = 1'b0;
  logic         xlat_fault = 1'b0;
  logic [39:0]  xlat_ppn = '0;
  logic         resp_valid;
  logic         resp_fault;
  logic [63:0]  resp_data;
  logic         mem_req_valid;
  logic [51:0]  mem_req_addr;
  logic         mem_resp_valid = 1'b0;
  logic [511:0] mem_resp_line = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vipt_cache u0 (.*);

  // Fields: ppn[53:14], voff[13:2], fault[1], expect_hit[0]
  localparam int NV = 30;
  localparam logic [53:0] VEC [NV] = '{
    {40'h100,          12'h148, 1'b0, 1'b0}, // R1 cold miss
    {40'h100,          12'h178, 1'b0, 1'b1}, // R6 installed, word 7
    {40'h80_0000_0100, 12'h140, 1'b0, 1'b0}, // R4 bit 39 differs
    {40'h100,          12'h140, 1'b0, 1'b1}, // R4
    {40'h80_0000_0100, 12'h150, 1'b0, 1'b1}, // R4
    {40'h222,          12'h140, 1'b1, 1'b0}, // R7 fault
    {40'h222,          12'h140, 1'b0, 1'b0}, // R7 nothing installed
    {40'h100,          12'h9C0, 1'b0, 1'b0}, // R2 other set
    {40'h100,          12'h148, 1'b0, 1'b1}, // R2
    {40'h300, 12'h240, 1'b0, 1'b0}, {40'h301, 12'h248, 1'b0, 1'b0}, // R8 fills
    {40'h302, 12'h250, 1'b0, 1'b0}, {40'h303, 12'h258, 1'b0, 1'b0},
    {40'h304, 12'h260, 1'b0, 1'b0}, {40'h305, 12'h268, 1'b0, 1'b0},
    {40'h306, 12'h270, 1'b0, 1'b0}, {40'h307, 12'h278, 1'b0, 1'b0},
    {40'h300, 12'h240, 1'b0, 1'b1}, {40'h301, 12'h240, 1'b0, 1'b1}, // R8 all resident
    {40'h302, 12'h240, 1'b0, 1'b1}, {40'h303, 12'h240, 1'b0, 1'b1},
    {40'h304, 12'h240, 1'b0, 1'b1}, {40'h305, 12'h240, 1'b0, 1'b1},
    {40'h306, 12'h240, 1'b0, 1'b1}, {40'h307, 12'h240, 1'b0, 1'b1},
    {40'h300, 12'h240, 1'b0, 1'b1}, // R9 touch way 0
    {40'h308, 12'h258, 1'b0, 1'b0}, // R9 evicts way 4
    {40'h300, 12'h240, 1'b0, 1'b1}, // R9 way 0 kept
    {40'h308, 12'h240, 1'b0, 1'b1}, // R9
    {40'h304, 12'h240, 1'b0, 1'b0}  // R9 way 4 was the victim
  };

  function automatic logic [63:0] line_word(input logic [51:0] pa, input int w);
    return {pa[51:6], 15'd0, 3'(w)};
  endfunction

  function automatic logic [511:0] make_line(input logic [51:0] pa);
    logic [511:0] l;
    for (int w = 0; w < 8; w++) l[w*64 +: 64] = line_word(pa, w);
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [39:0] ppn, input logic [11:0] off, input bit fault,
                        input bit exp_hit, input string req);
    logic [51:0] pa = {ppn, off[11:6], 6'd0};
    logic [63:0] exp_d = line_word(pa, int'(off[5:3]));
    @(negedge clk);
    req_valid = 1'b1; req_voff = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "ready while pending", 64'(req_ready), 64'd0);
    xlat_valid = 1'b1; xlat_ppn = ppn; xlat_fault = fault;
    @(negedge clk);
    xlat_valid = 1'b0; xlat_fault = 1'b0;
    if (fault) begin
      check(resp_valid && resp_fault && !mem_req_valid, "R7", "fault response",
            {61'd0, resp_valid, resp_fault, mem_req_valid}, 64'b110);
    end else if (mem_req_valid) begin
      check(!exp_hit, req, "unexpected miss", 64'd1, 64'd0);
      check(mem_req_addr == pa, "R5", "refill address", 64'(mem_req_addr), 64'(pa));
      mem_resp_valid = 1'b1; mem_resp_line = make_line(pa);
      @(negedge clk);
      mem_resp_valid = 1'b0;
      check(!mem_req_valid, "R5", "single request pulse", 64'(mem_req_valid), 64'd0);
      check(resp_valid && !resp_fault && resp_data == exp_d, "R6", "refill word",
            resp_data, exp_d);
    end else begin
      check(exp_hit, req, "unexpected hit", 64'(resp_valid), 64'd0);
      check(resp_valid && !resp_fault && resp_data == exp_d, "R3", "hit word",
            resp_data, exp_d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_req_valid, "R1", "reset outputs",
          {61'd0, req_ready, resp_valid, mem_req_valid}, 64'b100);

    for (int i = 0; i < NV; i++)
      access(VEC[i][53:14], VEC[i][13:2], VEC[i][1], VEC[i][0], "R2");

    // R3: translation without a pending lookup is ignored
    @(negedge clk);
    xlat_valid = 1'b1; xlat_fault = 1'b1; xlat_ppn = 40'h999;
    @(negedge clk);
    xlat_valid = 1'b0; xlat_fault = 1'b0;
    @(negedge clk);
    check(!resp_valid && !mem_req_valid, "R3", "idle translation ignored",
          {62'd0, resp_valid, mem_req_valid}, 64'd0);

    // R3: late translation, three idle cycles
    @(negedge clk);
    req_valid = 1'b1; req_voff = 12'h160;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!resp_valid && !mem_req_valid, "R3", "waits for translation",
            {62'd0, resp_valid, mem_req_valid}, 64'd0);
    end
    xlat_valid = 1'b1; xlat_ppn = 40'h100;
    @(negedge clk);
    xlat_valid = 1'b0;
    check(resp_valid && resp_data == line_word({40'h100, 6'd5, 6'd0}, 4), "R3",
          "late translation hit", resp_data, line_word({40'h100, 6'd5, 6'd0}, 4));

    // R10: request held high during a lookup is not taken
    @(negedge clk);
    req_valid = 1'b1; req_voff = 12'h148;
    @(negedge clk);
    req_voff = 12'h9F8;
    check(!req_ready, "R10", "busy ready", 64'(req_ready), 64'd0);
    xlat_valid = 1'b1; xlat_ppn = 40'h100;
    @(negedge clk);
    req_valid = 1'b0; xlat_valid = 1'b0;
    check(resp_valid && resp_data == line_word({40'h100, 6'd5, 6'd0}, 1), "R10",
          "first address kept", resp_data, line_word({40'h100, 6'd5, 6'd0}, 1));
    @(negedge clk);
    check(!resp_valid && !mem_req_valid && req_ready, "R10", "no second lookup",
          {61'd0, resp_valid, mem_req_valid, req_ready}, 64'b001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule